// File: doc/BRIEF.md
# Jump-Snooping ROM Bank Selector

This block watches the shared address and data bus of an 8-bit processor that runs code from a banked cartridge ROM, and drives the upper ROM address lines through a bank register. It picks out an absolute jump (opcode 0x4C) as the processor fetches it. It follows the two operand fetches that come after the opcode. It then loads a new bank from the target's high address byte at the clock edge that ends the high-byte fetch. The next fetch, the first at the jump target, therefore already comes from the new bank.

An opcode-fetch marker from the processor side tells the block which reads are instruction opcodes, so an operand or data byte equal to 0x4C never starts a jump. A single hotspot address is still decoded. Reading it steps the bank forward by one, so code written for fixed-address switching keeps working. A bus cycle is one clock with the read strobe high. The data byte is valid in that same cycle.

Top module: `jmp_bank_switcher`

## Requirements
- R1: Synchronous reset sets the bank to 7 and discards any partly seen jump, so a read right after reset cannot complete a jump.
- R2: Three consecutive read cycles complete a jump and load the bank. The first is an opcode fetch returning 0x4C at address A. The second is a non-opcode read at A+1. The third is a non-opcode read at A+2 returning byte H. The bank becomes H[7:5] and is visible in the cycle after the third read.
- R3: If the read after the 0x4C opcode is not at A+1, the sequence is dropped and the bank stays unchanged.
- R4: If the third read is not one above the second, the sequence is dropped and the bank stays unchanged.
- R5: A 0x4C returned on a read without the opcode-fetch marker starts no sequence. Later reads at consecutive addresses leave the bank unchanged.
- R6: Any read at the 13-bit address 0x1FF9 that does not complete a jump advances the bank by one, wrapping from 7 to 0, in the next cycle.
- R7: When the high-byte read of a jump falls on the hotspot address, the jump wins and the bank becomes H[7:5].
- R8: A cycle with the read strobe low leaves the bank unchanged and drops any partly seen jump.
- R9: Address succession wraps at 13 bits, so 0x0000 follows 0x1FFF within a jump sequence.
- R10: An opcode fetch in an operand slot restarts detection. If it returns 0x4C, the sequence restarts from that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one bus cycle per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 13 | Address of the current cycle |
| bus_data | input | 8 | Byte returned by the read in the current cycle |
| bus_rd | input | 1 | High when the current cycle is a read |
| op_fetch | input | 1 | High when the current read is an opcode fetch |
| rom_bank | output | 3 | Registered bank select for the upper ROM address lines |

## Verification
The assertions take for granted that the read strobe is low in every reset cycle, so no history held over from reset can look like a jump. They also assume the opcode-fetch marker is only high on reads. The jump property looks back two cycles at inputs alone, and the hotspot property applies only on opcode fetches, because those can never end a jump. The stimulus keeps the strobe low whenever reset is high. The vector table also places a hotspot read on a completing jump, crosses the 13-bit address wrap, and puts an opcode fetch in an operand slot.

// File: rtl/jbs_pkg.sv
package jbs_pkg;
  typedef enum logic [1:0] {
    DET_IDLE = 2'd0,
    DET_OPC  = 2'd1,
    DET_LO   = 2'd2
  } det_state_t;
endpackage

// File: rtl/jbs_jmp_detect.sv
module jbs_jmp_detect
  import jbs_pkg::*;
#(
  parameter int          ADDR_W = 13,
  parameter int          DATA_W = 8,
  parameter int          BANK_W = 3,
  parameter logic [7:0]  OPC_JMP = 8'h4C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              rd,
  input  logic              opfetch,
  output logic              fire,
  output logic [BANK_W-1:0] tgt_bank
);
  det_state_t        state_q, state_d;
  logic [ADDR_W-1:0] last_addr_q;
  logic [ADDR_W-1:0] succ_addr;
  logic              seq_ok;
  logic              arm;

  // successor of the previous read, wrapping at ADDR_W bits
  assign succ_addr = last_addr_q + ADDR_W'(1);
  assign seq_ok    = rd && !opfetch && (addr == succ_addr);
  assign arm       = rd && opfetch && (data == DATA_W'(OPC_JMP));
  assign fire      = (state_q == DET_LO) && seq_ok;
  assign tgt_bank  = data[DATA_W-1 -: BANK_W];

  always_comb begin
    state_d = DET_IDLE;
    if (rd) begin
      if (opfetch) begin
        state_d = arm ? DET_OPC : DET_IDLE;
      end else begin
        unique case (state_q)
          DET_OPC: state_d = seq_ok ? DET_LO : DET_IDLE;
          default: state_d = DET_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= DET_IDLE;
      last_addr_q <= '0;
    end else begin
      state_q <= state_d;
      if (rd) last_addr_q <= addr;
    end
  end
endmodule

// File: rtl/jbs_hotspot.sv
module jbs_hotspot #(
  parameter int                ADDR_W   = 13,
  parameter logic [ADDR_W-1:0] HOT_ADDR = 13'h1FF9
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  output logic              hit
);
  assign hit = rd && (addr == HOT_ADDR);
endmodule

// File: rtl/jbs_bank_reg.sv
module jbs_bank_reg #(
  parameter int              BANK_W     = 3,
  parameter logic [BANK_W-1:0] RESET_BANK = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              jmp_fire,
  input  logic [BANK_W-1:0] jmp_bank,
  input  logic              hot_hit,
  output logic [BANK_W-1:0] bank
);
  // a completing jump outranks the hotspot
  always_ff @(posedge clk) begin
    if (rst)           bank <= RESET_BANK;
    else if (jmp_fire) bank <= jmp_bank;
    else if (hot_hit)  bank <= bank + BANK_W'(1);
  end
endmodule

// File: rtl/jmp_bank_switcher.sv
module jmp_bank_switcher #(
  parameter int                ADDR_W     = 13,
  parameter int                DATA_W     = 8,
  parameter int                BANK_W     = 3,
  parameter logic [7:0]        OPC_JMP    = 8'h4C,
  parameter logic [ADDR_W-1:0] HOT_ADDR   = 13'h1FF9,
  parameter logic [BANK_W-1:0] RESET_BANK = 3'd7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_rd,
  input  logic              op_fetch,
  output logic [BANK_W-1:0] rom_bank
);
  logic              jmp_fire;
  logic [BANK_W-1:0] jmp_bank;
  logic              hot_hit;

  jbs_jmp_detect #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .OPC_JMP(OPC_JMP)
  ) u_det (
    .clk(clk), .rst(rst), .addr(bus_addr), .data(bus_data),
    .rd(bus_rd), .opfetch(op_fetch), .fire(jmp_fire), .tgt_bank(jmp_bank)
  );

  jbs_hotspot #(.ADDR_W(ADDR_W), .HOT_ADDR(HOT_ADDR)) u_hot (
    .addr(bus_addr), .rd(bus_rd), .hit(hot_hit)
  );

  jbs_bank_reg #(.BANK_W(BANK_W), .RESET_BANK(RESET_BANK)) u_bank (
    .clk(clk), .rst(rst), .jmp_fire(jmp_fire), .jmp_bank(jmp_bank),
    .hot_hit(hot_hit), .bank(rom_bank)
  );
endmodule

// File: rtl/jbs_checker.sv
module jbs_checker #(
  parameter int                ADDR_W     = 13,
  parameter int                DATA_W     = 8,
  parameter int                BANK_W     = 3,
  parameter logic [7:0]        OPC_JMP    = 8'h4C,
  parameter logic [ADDR_W-1:0] HOT_ADDR   = 13'h1FF9,
  parameter logic [BANK_W-1:0] RESET_BANK = 3'd7
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_data,
  input logic              bus_rd,
  input logic              op_fetch,
  input logic [BANK_W-1:0] rom_bank
);
  AST_RESET_BANK: assert property (@(posedge clk)
    rst |=> rom_bank == RESET_BANK); // R1

  AST_JUMP_LOADS: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !op_fetch && $past(bus_rd) && !$past(op_fetch)
     && $past(bus_rd, 2) && $past(op_fetch, 2)
     && $past(bus_data, 2) == DATA_W'(OPC_JMP)
     && bus_addr == ADDR_W'($past(bus_addr) + 1'b1)
     && $past(bus_addr) == ADDR_W'($past(bus_addr, 2) + 1'b1))
    |=> rom_bank == $past(bus_data[DATA_W-1 -: BANK_W])); // R2

  AST_HOTSPOT_STEP: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && op_fetch && bus_addr == HOT_ADDR)
    |=> rom_bank == BANK_W'($past(rom_bank) + 1'b1)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(rom_bank)); // R8
endmodule

bind jmp_bank_switcher jbs_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W),
  .OPC_JMP(OPC_JMP), .HOT_ADDR(HOT_ADDR), .RESET_BANK(RESET_BANK)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data(bus_data),
  .bus_rd(bus_rd), .op_fetch(op_fetch), .rom_bank(rom_bank)
);

// File: tb/jmp_bank_switcher_tb.sv
module jmp_bank_switcher_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [12:0] bus_addr;
  logic [7:0]  bus_data;
  logic        bus_rd;
  logic        op_fetch;
  logic [2:0]  rom_bank;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  jmp_bank_switcher u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_rd(bus_rd), .op_fetch(op_fetch), .rom_bank(rom_bank)
  );

  // {req[3:0], rst, rd, op, addr[12:0], data[7:0], exp_bank[2:0]}
  localparam int NV = 33;
  localparam logic [30:0] VEC [0:NV-1] = '{
    {4'd1,  1'b1,1'b0,1'b0,13'h0000,8'h00,3'd7}, // R1
    {4'd1,  1'b1,1'b0,1'b0,13'h0000,8'h00,3'd7}, // R1
    {4'd8,  1'b0,1'b0,1'b0,13'h0000,8'h00,3'd7}, // R8
    {4'd2,  1'b0,1'b1,1'b1,13'h1000,8'h4C,3'd7}, // R2
    {4'd2,  1'b0,1'b1,1'b0,13'h1001,8'h00,3'd7}, // R2
    {4'd2,  1'b0,1'b1,1'b0,13'h1002,8'h40,3'd2}, // R2
    {4'd2,  1'b0,1'b1,1'b1,13'h4000,8'hEA,3'd2}, // R2
    {4'd6,  1'b0,1'b1,1'b1,13'h1FF9,8'h00,3'd3}, // R6
    {4'd3,  1'b0,1'b1,1'b1,13'h0100,8'h4C,3'd3}, // R3
    {4'd3,  1'b0,1'b1,1'b0,13'h0105,8'h00,3'd3}, // R3
    {4'd3,  1'b0,1'b1,1'b0,13'h0106,8'hE0,3'd3}, // R3
    {4'd4,  1'b0,1'b1,1'b1,13'h0200,8'h4C,3'd3}, // R4
    {4'd4,  1'b0,1'b1,1'b0,13'h0201,8'h00,3'd3}, // R4
    {4'd4,  1'b0,1'b1,1'b0,13'h0203,8'hE0,3'd3}, // R4
    {4'd5,  1'b0,1'b1,1'b0,13'h0300,8'h4C,3'd3}, // R5
    {4'd5,  1'b0,1'b1,1'b0,13'h0301,8'h00,3'd3}, // R5
    {4'd5,  1'b0,1'b1,1'b0,13'h0302,8'hE0,3'd3}, // R5
    {4'd7,  1'b0,1'b1,1'b1,13'h1FF7,8'h4C,3'd3}, // R7
    {4'd7,  1'b0,1'b1,1'b0,13'h1FF8,8'h00,3'd3}, // R7
    {4'd7,  1'b0,1'b1,1'b0,13'h1FF9,8'hA0,3'd5}, // R7
    {4'd8,  1'b0,1'b1,1'b1,13'h0400,8'h4C,3'd5}, // R8
    {4'd8,  1'b0,1'b0,1'b0,13'h0401,8'h00,3'd5}, // R8
    {4'd8,  1'b0,1'b1,1'b0,13'h0401,8'h00,3'd5}, // R8
    {4'd8,  1'b0,1'b1,1'b0,13'h0402,8'h20,3'd5}, // R8
    {4'd9,  1'b0,1'b1,1'b1,13'h1FFF,8'h4C,3'd5}, // R9
    {4'd9,  1'b0,1'b1,1'b0,13'h0000,8'h11,3'd5}, // R9
    {4'd9,  1'b0,1'b1,1'b0,13'h0001,8'h60,3'd3}, // R9
    {4'd10, 1'b0,1'b1,1'b1,13'h0500,8'h4C,3'd3}, // R10
    {4'd10, 1'b0,1'b1,1'b1,13'h0501,8'h4C,3'd3}, // R10
    {4'd10, 1'b0,1'b1,1'b0,13'h0502,8'h00,3'd3}, // R10
    {4'd10, 1'b0,1'b1,1'b0,13'h0503,8'hC0,3'd6}, // R10
    {4'd6,  1'b0,1'b1,1'b0,13'h1FF9,8'h00,3'd7}, // R6
    {4'd6,  1'b0,1'b1,1'b0,13'h1FF9,8'h00,3'd0}  // R6 wrap
  };

  task automatic drive(input logic r, input logic rd, input logic op,
                       input logic [12:0] a, input logic [7:0] d);
    rst = r; bus_rd = rd; op_fetch = op; bus_addr = a; bus_data = d;
  endtask

  task automatic check(input int req, input logic [2:0] exp);
    n_checks++;
    if (rom_bank !== exp) begin
      n_fail++;
      $display("FAIL R%0d: rom_bank=%0d expected %0d", req, rom_bank, exp);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    drive(1'b1, 1'b0, 1'b0, '0, '0);
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][26], VEC[i][25], VEC[i][24], VEC[i][23:11], VEC[i][10:3]);
      @(negedge clk);
      check(int'(VEC[i][30:27]), VEC[i][2:0]);
    end

    // R1: reset in the middle of a jump sequence drops it
    drive(1'b0, 1'b1, 1'b1, 13'h0600, 8'h4C); @(negedge clk);
    drive(1'b0, 1'b1, 1'b0, 13'h0601, 8'h00); @(negedge clk);
    drive(1'b1, 1'b0, 1'b0, 13'h0602, 8'h00); @(negedge clk);
    check(1, 3'd7);
    drive(1'b0, 1'b1, 1'b0, 13'h0602, 8'h20); @(negedge clk);
    check(1, 3'd7);

    // R2: back-to-back jumps, the second fetched from the new bank
    drive(1'b0, 1'b1, 1'b1, 13'h0700, 8'h4C); @(negedge clk);
    drive(1'b0, 1'b1, 1'b0, 13'h0701, 8'h00); @(negedge clk);
    drive(1'b0, 1'b1, 1'b0, 13'h0702, 8'h80); @(negedge clk);
    check(2, 3'd4);
    drive(1'b0, 1'b1, 1'b1, 13'h0000, 8'h4C); @(negedge clk);
    drive(1'b0, 1'b1, 1'b0, 13'h0001, 8'h34); @(negedge clk);
    drive(1'b0, 1'b1, 1'b0, 13'h0002, 8'h3F); @(negedge clk);
    check(2, 3'd1);

    drive(1'b0, 1'b0, 1'b0, '0, '0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule